// File: doc/BRIEF.md
# No-Turnaround Pipelined Synchronous SRAM

This block is a single-port synchronous static RAM with a 32-bit word split into four byte lanes. Every input is captured on the rising clock edge, and one command (read, write or deselect) is accepted per enabled cycle. Reads and writes may follow each other in any order with no idle slot between them. The data bus never needs a turnaround cycle because write data is placed two enabled cycles behind its command, the same slot in which read data comes out.

A write command is held in a two-stage pipeline until its data arrives, and then it is committed to the array. A read that targets the address of a write still waiting in that pipeline gets that write's enabled bytes merged into its result, so every read returns the value left by all earlier commands. An active-high hold input freezes the whole pipeline. The address of each cycle comes from outside, for example from a burst address generator. The default address width is 10 bits (1024 words); setting `AW` to 18 gives the full 262,144-word array.

Top module: `nt_sram`

## Requirements
- R1: While `rst` is high at a clock edge, `rvalid` is low after that edge and stays low until a read command has gone through the pipeline.
- R2: A read accepted at enabled edge E drives `rvalid` high and `rdata` with the word at its address after enabled edge E+2. For any other command at E, `rvalid` is low after E+2.
- R3: A write accepted at enabled edge E takes its data from `wdata` at enabled edge E+2 and commits it to the address given at E.
- R4: `byte_we[i]` set to 1 writes bits 8i+7..8i of the word; lanes whose bit is 0 keep their old value, and a write with `byte_we` all zero changes nothing.
- R5: A read issued on the enabled cycle right after a write to the same address returns the old word with the enabled bytes of that write merged in, with no wait cycle.
- R6: A deselect (`cs` low) writes nothing and produces `rvalid` low in its output slot.
- R7: While `clk_hold` is high, every other input is ignored: `rvalid` and `rdata` keep their values and no write reaches the array.
- R8: A read issued right before a write to the same address returns the word as it was before that write.
- R9: Any mix of read, write and deselect commands on consecutive enabled cycles, with holds between them, gives every read the value left by all commands accepted before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_hold | input | 1 | High freezes all pipeline state and ignores inputs |
| cs | input | 1 | Command select; low means deselect |
| wr_n | input | 1 | Low selects write, high selects read |
| byte_we | input | NB (4) | Per-lane write enable, bit i covers bits 8i+7..8i |
| addr | input | AW (10) | Word address of the command |
| wdata | input | DW (32) | Write data, sampled two enabled edges after its command |
| rdata | output | DW (32) | Read data, registered |
| rvalid | output | 1 | High when `rdata` holds the result of a read |

## Verification
The case that needs care is a write committing to the array at the same edge that a read of that address samples the array, so the read must be answered from the forwarding path and not from storage. The bench provokes it with directed write-then-read pairs using partial byte masks, and with a random mix confined to 16 addresses so that such collisions come up often, with holds inserted between them. Each read result is judged against a bench model that applies every command in the order it was accepted.

// File: rtl/nt_sram_pkg.sv
package nt_sram_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/nt_sram_cmd_pipe.sv
module nt_sram_cmd_pipe
  import nt_sram_pkg::*;
#(
  parameter int AW = 10,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          cs,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [NB-1:0] byte_we,
  output op_e           s1_op,
  output logic [AW-1:0] s1_addr,
  output op_e           s2_op,
  output logic [AW-1:0] s2_addr,
  output logic [NB-1:0] s2_be
);
  op_e           cmd_op;
  logic [NB-1:0] s1_be;

  always_comb begin
    if (!cs)       cmd_op = OP_NONE;
    else if (wr_n) cmd_op = OP_RD;
    else           cmd_op = OP_WR;
  end

  // command stage one: captured at the accepting edge
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op <= OP_NONE;
    end else if (en) begin
      s1_op <= cmd_op;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      s1_addr <= addr;
      s1_be   <= byte_we;
    end
  end

  // command stage two: write waits here for its data
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_op <= OP_NONE;
    end else if (en) begin
      s2_op <= s1_op;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
    end
  end
endmodule

// File: rtl/nt_sram_array.sv
module nt_sram_array #(
  parameter int AW = 10,
  parameter int NB = 4,
  parameter int LW = 8,
  localparam int DW    = NB * LW,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic [NB-1:0] we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata_q
);
  // one simple dual-port memory per lane, read-first on a shared address
  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LW-1:0] lane_mem [DEPTH];
    logic [LW-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (we[g]) begin
        lane_mem[waddr] <= wdata[g*LW +: LW];
      end
    end

    always_ff @(posedge clk) begin
      if (re) begin
        lane_q <= lane_mem[raddr];
      end
    end

    assign rdata_q[g*LW +: LW] = lane_q;
  end
endmodule

// File: rtl/nt_sram_rdpath.sv
module nt_sram_rdpath
  import nt_sram_pkg::*;
#(
  parameter int AW = 10,
  parameter int NB = 4,
  parameter int LW = 8,
  localparam int DW = NB * LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  op_e           s1_op,
  input  logic [AW-1:0] s1_addr,
  input  op_e           s2_op,
  input  logic [AW-1:0] s2_addr,
  input  logic [NB-1:0] s2_be,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] arr_q,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic          pend_rd;
  logic [NB-1:0] fwd_mask;
  logic [DW-1:0] fwd_data;
  logic          hit;
  logic [DW-1:0] merged;

  // the write in stage two commits on the same edge the read samples the array
  assign hit = (s1_op == OP_RD) && (s2_op == OP_WR) && (s2_addr == s1_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_rd  <= 1'b0;
      fwd_mask <= '0;
    end else if (en) begin
      pend_rd  <= (s1_op == OP_RD);
      fwd_mask <= hit ? s2_be : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      fwd_data <= wdata;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_merge
    assign merged[g*LW +: LW] = fwd_mask[g] ? fwd_data[g*LW +: LW] : arr_q[g*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else if (en) begin
      rvalid <= pend_rd;
      if (pend_rd) begin
        rdata <= merged;
      end
    end
  end
endmodule

// File: rtl/nt_sram.sv
module nt_sram
  import nt_sram_pkg::*;
#(
  parameter int AW = 10,
  parameter int NB = 4,
  localparam int DW = NB * LANE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clk_hold,
  input  logic          cs,
  input  logic          wr_n,
  input  logic [NB-1:0] byte_we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic          en;
  op_e           s1_op;
  op_e           s2_op;
  logic [AW-1:0] s1_addr;
  logic [AW-1:0] s2_addr;
  logic [NB-1:0] s2_be;
  logic [NB-1:0] mem_we;
  logic          mem_re;
  logic [DW-1:0] arr_q;

  assign en     = !clk_hold;
  assign mem_we = (en && s2_op == OP_WR) ? s2_be : '0;
  assign mem_re = en && (s1_op == OP_RD);

  nt_sram_cmd_pipe #(.AW(AW), .NB(NB)) u_cmd (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .cs      (cs),
    .wr_n    (wr_n),
    .addr    (addr),
    .byte_we (byte_we),
    .s1_op   (s1_op),
    .s1_addr (s1_addr),
    .s2_op   (s2_op),
    .s2_addr (s2_addr),
    .s2_be   (s2_be)
  );

  nt_sram_array #(.AW(AW), .NB(NB), .LW(LANE_W)) u_arr (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (s2_addr),
    .wdata   (wdata),
    .re      (mem_re),
    .raddr   (s1_addr),
    .rdata_q (arr_q)
  );

  nt_sram_rdpath #(.AW(AW), .NB(NB), .LW(LANE_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .s1_op   (s1_op),
    .s1_addr (s1_addr),
    .s2_op   (s2_op),
    .s2_addr (s2_addr),
    .s2_be   (s2_be),
    .wdata   (wdata),
    .arr_q   (arr_q),
    .rdata   (rdata),
    .rvalid  (rvalid)
  );
endmodule

// File: rtl/nt_sram_chk.sv
module nt_sram_chk #(
  parameter int NB = 4,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          clk_hold,
  input logic          cs,
  input logic          wr_n,
  input logic [NB-1:0] mem_we,
  input logic [DW-1:0] rdata,
  input logic          rvalid
);
  logic rd1, rd2, wr1, wr2;

  // independent record of accepted commands, two enabled edges deep
  always_ff @(posedge clk) begin
    if (rst) begin
      rd1 <= 1'b0; rd2 <= 1'b0; wr1 <= 1'b0; wr2 <= 1'b0;
    end else if (!clk_hold) begin
      rd1 <= cs && wr_n;  rd2 <= rd1;
      wr1 <= cs && !wr_n; wr2 <= wr1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !rvalid); // R1

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    !clk_hold |=> (rvalid == $past(rd2))); // R2

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    clk_hold |=> ($stable(rvalid) && $stable(rdata))); // R7

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    clk_hold |-> (mem_we == '0)); // R7

  AST_WRITE_ONLY_FROM_WR: assert property (@(posedge clk) disable iff (rst)
    (mem_we != '0) |-> wr2); // R6
endmodule

bind nt_sram nt_sram_chk #(.NB(NB), .DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clk_hold (clk_hold),
  .cs       (cs),
  .wr_n     (wr_n),
  .mem_we   (mem_we),
  .rdata    (rdata),
  .rvalid   (rvalid)
);

// File: tb/tb_nt_sram.sv
`timescale 1ns/1ps
module tb_nt_sram;
  localparam int AW = 10;
  localparam int NB = 4;
  localparam int DW = 32;
  localparam int NADDR = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clk_hold = 1'b0;
  logic          cs = 1'b0;
  logic          wr_n = 1'b1;
  logic [NB-1:0] byte_we = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rvalid;

  int checks = 0;
  int failures = 0;

  logic [DW-1:0] model [NADDR];
  int            q_typ [2];
  logic [DW-1:0] q_dat [2];
  logic [DW-1:0] q_exp [2];
  string         q_tag [2];
  logic          prev_v;
  logic [DW-1:0] prev_d;

  always #4 clk = ~clk;

  nt_sram #(.AW(AW), .NB(NB)) dut (
    .clk(clk), .rst(rst), .clk_hold(clk_hold), .cs(cs), .wr_n(wr_n),
    .byte_we(byte_we), .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                               input logic [DW-1:0] new_w,
                                               input logic [NB-1:0] be);
    logic [DW-1:0] r = old_w;
    for (int i = 0; i < NB; i++) if (be[i]) r[i*8 +: 8] = new_w[i*8 +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // op: 0 deselect, 1 read, 2 write
  task automatic step(input bit h, input int op, input int a, input logic [NB-1:0] be,
                      input logic [DW-1:0] d, input string tag);
    @(negedge clk);
    clk_hold = h;
    cs       = (op != 0);
    wr_n     = (op != 2);
    addr     = AW'(a);
    byte_we  = be;
    wdata    = (!h && q_typ[1] == 2) ? q_dat[1] : $urandom;
    @(posedge clk);
    #1;
    if (h) begin
      chk(rvalid == prev_v, "R7 valid held", DW'(rvalid), DW'(prev_v));
      chk(rdata == prev_d, "R7 data held", rdata, prev_d);
    end else begin
      chk(rvalid == (q_typ[1] == 1), {q_tag[1], " valid"}, DW'(rvalid), DW'(q_typ[1] == 1));
      if (q_typ[1] == 1) chk(rdata == q_exp[1], {q_tag[1], " data"}, rdata, q_exp[1]);
      q_typ[1] = q_typ[0]; q_dat[1] = q_dat[0]; q_exp[1] = q_exp[0]; q_tag[1] = q_tag[0];
      q_typ[0] = op; q_dat[0] = d; q_tag[0] = tag;
      q_exp[0] = (op == 1) ? model[a] : '0;
      if (op == 2) model[a] = lane_merge(model[a], d, be);
    end
    prev_v = rvalid;
    prev_d = rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin q_typ[i] = 0; q_dat[i] = '0; q_exp[i] = '0; q_tag[i] = "R6"; end
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(rvalid == 1'b0, "R1 reset", DW'(rvalid), 32'd0);
    prev_v = rvalid; prev_d = rdata;

    // prefill every address used by the bench (R3)
    for (int a = 0; a < NADDR; a++) step(0, 2, a, 4'hF, 32'hA5000000 | (a * 32'h01010101), "R3");
    step(0, 0, 0, 4'h0, '0, "R6 deselect");
    step(0, 0, 0, 4'h0, '0, "R6 deselect");
    step(0, 1, 3, 4'h0, '0, "R2 read after fill");
    step(0, 1, 9, 4'h0, '0, "R2 back to back read");
    // write immediately followed by read of same address, partial mask (R5, R4)
    step(0, 2, 5, 4'b0101, 32'h11223344, "R4");
    step(0, 1, 5, 4'h0, '0, "R5 forward partial");
    // read then write same address returns old word (R8)
    step(0, 1, 6, 4'h0, '0, "R8 read before write");
    step(0, 2, 6, 4'hF, 32'hDEADBEEF, "R3");
    step(0, 1, 6, 4'h0, '0, "R3 write committed");
    // write with no lanes enabled (R4)
    step(0, 2, 7, 4'h0, 32'hFFFFFFFF, "R4");
    step(0, 1, 7, 4'h0, '0, "R4 empty mask unchanged");
    // holds between a write and its data slot (R7)
    step(0, 2, 8, 4'b1000, 32'h77665544, "R7");
    step(1, 2, 8, 4'hF, 32'h0, "R7");
    step(1, 1, 8, 4'hF, 32'h0, "R7");
    step(0, 1, 8, 4'h0, '0, "R7 hold ignored inputs");
    step(0, 0, 2, 4'hF, '0, "R6 deselect");
    step(0, 1, 2, 4'h0, '0, "R6 deselect wrote nothing");

    // random mix over a small address set (R9)
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 5);
      op = (op == 0) ? 0 : ((op < 3) ? 2 : 1);
      step(($urandom_range(0, 4) == 0), op, $urandom_range(0, NADDR - 1),
           4'($urandom), $urandom, "R9 random mix");
    end
    for (int n = 0; n < 3; n++) step(0, 0, 0, 4'h0, '0, "R6 drain");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule